// File: doc/BRIEF.md
# Descriptor-Ring Audio DMA Channel

This block is a single bus-master channel for audio transfers. It works through a ring of 32 buffer descriptors that software places in system memory. Each descriptor takes 8 bytes. The first 32-bit word is the buffer address. The second word holds a 16-bit sample count in bits 15:0 and an interrupt-on-completion flag in bit 31. Software sets up the ring and controls the channel through a small register set. The channel reads each descriptor through a request/valid memory read port. It then counts down the samples of the current buffer and moves from buffer to buffer until it finishes the buffer whose index software marked as the last valid one.

The sample data path is not part of this block. A one-cycle `sample_take` strobe marks each sample the data path has consumed. A `xfer_fault` strobe marks a transfer error. Status events combine with their enable bits to drive a level interrupt toward an interrupt controller.

A halted ring can resume without a restart. If the channel has halted at the last valid buffer and the run bit is still set, software writes a new last-valid index that differs from the current index. The channel then moves on by itself.

Register offsets on `reg_addr`: 0x0 ring base, 0x4 control, 0x5 last-valid index, 0x6 status, 0x8 current index, 0x9 prefetch index, 0xA remaining count. Reads return the selected register zero-extended, in the same cycle.

Top module: `dma_ring_chan`

## Requirements
- R1: A write to the ring base (offset 0x0) stores the value with bits 2:0 cleared, so 0x5555_555F reads back as 0x5555_5558.
- R2: A write to the last-valid index (offset 0x5) keeps only the value modulo 32, so 0x25 reads back as 0x05.
- R3: Writes to the current index (0x8), prefetch index (0x9) and remaining count (0xA) have no effect on those registers.
- R4: After reset, status (0x6) reads 0x0001 and every other register reads 0. Control (0x4) reads back only bits 4:0: bit 0 run, bit 1 register reset, bit 2 last-valid interrupt enable, bit 3 fault interrupt enable, bit 4 completion interrupt enable.
- R5: A control write that changes run from 0 to 1 sets current index to 0 and prefetch index to 1, and clears status bit 0 (halted). The channel then fetches descriptor 0 with a read at base+0 followed by a read at base+4. A run write while run is already 1 leaves the indices unchanged and starts no fetch.
- R6: A control write with run 0 sets the halted bit and stops both fetching and sample counting. A control write with bit 1 set returns every register to its reset value.
- R7: Each `sample_take` lowers the remaining count by one. When the count reaches zero the buffer is complete. If the completed index is not the last-valid index, the current index takes the prefetch index, the prefetch index advances modulo 32, and the descriptor at base+index*8 is fetched. `buf_addr` shows the fetched buffer address with bits 1:0 cleared.
- R8: A completed buffer whose descriptor has bit 31 set sets status bit 3. Writing 1 to status bits 2, 3 or 4 clears them. Writing status bits 0 and 1 has no effect.
- R9: Completion of the buffer at the last-valid index sets status bits 0 (halted), 1 (current equals last) and 2 (last-valid done), and no further descriptor is read.
- R10: A last-valid write resumes the channel when run is 1, the channel is halted, and the current index differs from the new value. On resume, status bits 0 and 1 clear, the current index takes the prefetch index, the prefetch index advances, and that descriptor is fetched. A value equal to the current index leaves the channel halted.
- R11: A fetched descriptor with a sample count of 0 completes at once, with no `sample_take`, and the ring moves on.
- R12: `irq` is high while status bit 2 is set with control bit 2, or status bit 3 with control bit 4, or status bit 4 with control bit 3. A `xfer_fault` pulse sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register, zero-extended |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| sample_take | input | 1 | One sample consumed from the current buffer |
| xfer_fault | input | 1 | Transfer error strobe |
| buf_addr | output | 32 | Address of the current buffer |
| irq | output | 1 | Level interrupt request |

## Verification
Some rules are checked by assertions on every cycle:
- a run start always yields current index 0 and prefetch 1;
- a pause always sets the halted bit;
- memory is only requested while the channel runs and is not halted;
- every completion either advances the ring by one modulo 32 or raises all three end-of-ring status bits;
- the interrupt never rises without a pending event.

The scenarios cover what only a sequence can show:
- the exact descriptor addresses and their order, matched by a scoreboard;
- the chain through an empty descriptor;
- resume and non-resume on last-valid rewrites;
- the wrap of the prefetch index past 31;
- register masking;
- the full register reset.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;

    // register offsets
    localparam logic [3:0] OFS_BASE = 4'h0;
    localparam logic [3:0] OFS_CTRL = 4'h4;
    localparam logic [3:0] OFS_LAST = 4'h5;
    localparam logic [3:0] OFS_STAT = 4'h6;
    localparam logic [3:0] OFS_CUR  = 4'h8;
    localparam logic [3:0] OFS_PRE  = 4'h9;
    localparam logic [3:0] OFS_REM  = 4'hA;

    // status bit positions
    localparam int ST_HALT = 0;
    localparam int ST_CEL  = 1;
    localparam int ST_LVB  = 2;
    localparam int ST_BC   = 3;
    localparam int ST_FE   = 4;
    localparam int ST_W    = 5;
    localparam logic [ST_W-1:0] STAT_RST  = 5'b00001;
    localparam logic [ST_W-1:0] STAT_W1C  = 5'b11100;

    // control bit positions
    localparam int CT_RUN   = 0;
    localparam int CT_RR    = 1;
    localparam int CT_LVBIE = 2;
    localparam int CT_FEIE  = 3;
    localparam int CT_IOCE  = 4;
    localparam int CT_W     = 5;

    // interrupt sources: status bit and its enable bit
    localparam int N_IRQ_SRC = 3;
    function automatic int irq_stat_bit(input int k);
        return (k == 0) ? ST_LVB : (k == 1) ? ST_BC : ST_FE;
    endfunction
    function automatic int irq_en_bit(input int k);
        return (k == 0) ? CT_LVBIE : (k == 1) ? CT_IOCE : CT_FEIE;
    endfunction

    typedef enum logic [1:0] {PH_IDLE, PH_FETCH, PH_PLAY} phase_e;
    typedef enum logic [2:0] {F_IDLE, F_REQ_PTR, F_WAIT_PTR, F_REQ_CTL, F_WAIT_CTL} fetch_e;

endpackage

// File: rtl/ring_desc_fetch.sv
module ring_desc_fetch
    import dma_ring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] desc_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [CNT_W-1:0]  count,
    output logic              ioc
);
    localparam int WORD_BYTES = DATA_W / 8;

    typedef struct packed {
        fetch_e            st;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] ptr;
    } fetch_t;

    fetch_t q, n;

    always_comb begin
        n    = q;
        done = 1'b0;
        case (q.st)
            F_REQ_PTR:  n.st = F_WAIT_PTR;
            F_WAIT_PTR: if (mem_valid) begin
                n.ptr = {mem_rdata[ADDR_W-1:2], 2'b00};
                n.st  = F_REQ_CTL;
            end
            F_REQ_CTL:  n.st = F_WAIT_CTL;
            F_WAIT_CTL: if (mem_valid) begin
                done = 1'b1;
                n.st = F_IDLE;
            end
            default:    n.st = F_IDLE;
        endcase
        if (start) begin
            n.st   = F_REQ_PTR;
            n.addr = desc_addr;
        end
        if (abort) n.st = F_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: F_IDLE, addr: '0, ptr: '0};
        else        q <= n;
    end

    assign mem_req  = (q.st == F_REQ_PTR) || (q.st == F_REQ_CTL);
    assign mem_addr = (q.st == F_REQ_CTL) ? q.addr + ADDR_W'(WORD_BYTES) : q.addr;
    assign buf_addr = q.ptr;
    assign count    = mem_rdata[CNT_W-1:0];
    assign ioc      = mem_rdata[DATA_W-1];

    logic unused_rdata;
    assign unused_rdata = ^{mem_rdata[DATA_W-2:CNT_W], mem_rdata[1:0]};

endmodule

// File: rtl/ring_irq_merge.sv
module ring_irq_merge #(
    parameter int N_SRC = 3
) (
    input  logic [N_SRC-1:0] src_flag,
    input  logic [N_SRC-1:0] src_en,
    output logic             irq
);
    logic [N_SRC-1:0] hit;

    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        assign hit[k] = src_flag[k] & src_en[k];
    end

    assign irq = |hit;

endmodule

// File: rtl/dma_ring_chan.sv
module dma_ring_chan
    import dma_ring_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int RING_DEPTH = 32,
    parameter int DESC_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [31:0]       mem_rdata,
    input  logic              sample_take,
    input  logic              xfer_fault,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              irq
);
    localparam int IDX_W = $clog2(RING_DEPTH);
    localparam int DSH   = $clog2(DESC_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CT_W-1:0]   ctrl;
        logic [IDX_W-1:0]  last;
        logic [ST_W-1:0]   stat;
        logic [IDX_W-1:0]  cur;
        logic [IDX_W-1:0]  pre;
        logic [CNT_W-1:0]  rem;
        logic              ioc;
        logic [ADDR_W-1:0] bufa;
        phase_e            phase;
    } chan_t;

    localparam chan_t CHAN_RST = '{base: '0, ctrl: '0, last: '0, stat: STAT_RST,
                                   cur: '0, pre: '0, rem: '0, ioc: 1'b0,
                                   bufa: '0, phase: PH_IDLE};

    chan_t q, n;

    logic              wr_base, wr_ctrl, wr_last, wr_stat;
    logic              complete, cmp_ioc, fetch_go, abort;
    logic [IDX_W-1:0]  fetch_idx;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fd_done, fd_ioc;
    logic [ADDR_W-1:0] fd_buf;
    logic [CNT_W-1:0]  fd_cnt;

    assign wr_base = reg_wr && (reg_addr == OFS_BASE);
    assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_last = reg_wr && (reg_addr == OFS_LAST);
    assign wr_stat = reg_wr && (reg_addr == OFS_STAT);

    always_comb begin
        n         = q;
        complete  = 1'b0;
        cmp_ioc   = 1'b0;
        fetch_go  = 1'b0;
        fetch_idx = q.cur;
        abort     = 1'b0;

        if (wr_stat) n.stat = q.stat & ~(reg_wdata[ST_W-1:0] & STAT_W1C);
        if (xfer_fault) n.stat[ST_FE] = 1'b1;

        // sample consumption
        if (q.phase == PH_PLAY && sample_take && q.rem != '0) begin
            n.rem = q.rem - 1'b1;
            if (q.rem == CNT_W'(1)) begin
                complete = 1'b1;
                cmp_ioc  = q.ioc;
            end
        end

        // descriptor arrival
        if (fd_done) begin
            n.bufa  = fd_buf;
            n.rem   = fd_cnt;
            n.ioc   = fd_ioc;
            n.phase = PH_PLAY;
            if (fd_cnt == '0) begin
                complete = 1'b1;
                cmp_ioc  = fd_ioc;
            end
        end

        // buffer completion
        if (complete) begin
            if (cmp_ioc) n.stat[ST_BC] = 1'b1;
            if (q.cur == q.last) begin
                n.stat[ST_HALT] = 1'b1;
                n.stat[ST_CEL]  = 1'b1;
                n.stat[ST_LVB]  = 1'b1;
                n.phase         = PH_IDLE;
            end else begin
                n.cur     = q.pre;
                n.pre     = q.pre + 1'b1;
                fetch_go  = 1'b1;
                fetch_idx = q.pre;
                n.phase   = PH_FETCH;
            end
        end

        if (wr_base) n.base = {reg_wdata[ADDR_W-1:DSH], {DSH{1'b0}}};

        if (wr_last) begin
            n.last = reg_wdata[IDX_W-1:0];
            if (q.ctrl[CT_RUN] && n.stat[ST_HALT] && n.cur != reg_wdata[IDX_W-1:0]) begin
                n.stat[ST_HALT] = 1'b0;
                n.stat[ST_CEL]  = 1'b0;
                fetch_idx       = n.pre;
                n.cur           = n.pre;
                n.pre           = n.pre + 1'b1;
                fetch_go        = 1'b1;
                n.phase         = PH_FETCH;
            end
        end

        if (wr_ctrl) begin
            if (reg_wdata[CT_RR]) begin
                n        = CHAN_RST;
                fetch_go = 1'b0;
                abort    = 1'b1;
            end else begin
                if (!reg_wdata[CT_RUN]) begin
                    n.stat[ST_HALT] = 1'b1;
                    n.phase         = PH_IDLE;
                    fetch_go        = 1'b0;
                    abort           = 1'b1;
                end else if (!q.ctrl[CT_RUN]) begin
                    n.cur           = '0;
                    n.pre           = IDX_W'(1);
                    n.stat[ST_HALT] = 1'b0;
                    fetch_idx       = '0;
                    fetch_go        = 1'b1;
                    n.phase         = PH_FETCH;
                end
                n.ctrl = reg_wdata[CT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CHAN_RST;
        else        q <= n;
    end

    assign fetch_addr = q.base + (ADDR_W'(fetch_idx) << DSH);

    ring_desc_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(32)) i_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fetch_go),
        .abort     (abort),
        .desc_addr (fetch_addr),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata),
        .done      (fd_done),
        .buf_addr  (fd_buf),
        .count     (fd_cnt),
        .ioc       (fd_ioc)
    );

    logic [N_IRQ_SRC-1:0] irq_flag, irq_en;
    for (genvar k = 0; k < N_IRQ_SRC; k++) begin : g_irq_map
        assign irq_flag[k] = q.stat[irq_stat_bit(k)];
        assign irq_en[k]   = q.ctrl[irq_en_bit(k)];
    end

    ring_irq_merge #(.N_SRC(N_IRQ_SRC)) i_irq (
        .src_flag (irq_flag),
        .src_en   (irq_en),
        .irq      (irq)
    );

    always_comb begin
        case (reg_addr)
            OFS_BASE: reg_rdata = 32'(q.base);
            OFS_CTRL: reg_rdata = 32'(q.ctrl);
            OFS_LAST: reg_rdata = 32'(q.last);
            OFS_STAT: reg_rdata = 32'(q.stat);
            OFS_CUR:  reg_rdata = 32'(q.cur);
            OFS_PRE:  reg_rdata = 32'(q.pre);
            OFS_REM:  reg_rdata = 32'(q.rem);
            default:  reg_rdata = '0;
        endcase
    end

    assign buf_addr = q.bufa;

    // named views for the bound checker
    logic [ST_W-1:0]  stat_q;
    logic [IDX_W-1:0] cur_q, pre_q, last_q;
    logic             run_q, cmp_w;
    assign stat_q = q.stat;
    assign cur_q  = q.cur;
    assign pre_q  = q.pre;
    assign last_q = q.last;
    assign run_q  = q.ctrl[CT_RUN];
    assign cmp_w  = complete;

endmodule

// File: rtl/ring_chk.sv
module ring_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [3:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             mem_req,
    input logic             irq,
    input logic             cmp,
    input logic             run,
    input logic [4:0]       stat,
    input logic [IDX_W-1:0] cur,
    input logic [IDX_W-1:0] pre,
    input logic [IDX_W-1:0] last
);
    logic ctrl_wr, last_wr;
    assign ctrl_wr = reg_wr && (reg_addr == 4'h4);
    assign last_wr = reg_wr && (reg_addr == 4'h5);

    a_r5_run_start: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !reg_wdata[1] && reg_wdata[0] && !run
        |=> cur == '0 && pre == IDX_W'(1) && !stat[0]);

    a_r6_pause_halts: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !reg_wdata[1] && !reg_wdata[0] |=> stat[0]);

    a_r7_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
        cmp && cur != last && !ctrl_wr && !last_wr
        |=> cur == $past(pre) && pre == IDX_W'($past(pre) + 1'b1));

    a_r9_last_done: assert property (@(posedge clk) disable iff (!rst_n)
        cmp && cur == last && !ctrl_wr && !last_wr
        |=> stat[0] && stat[1] && stat[2]);

    a_r9_no_fetch_halted: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> run && !stat[0]);

    a_r12_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat[4:2] != 3'b000);

endmodule

bind dma_ring_chan ring_chk i_ring_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .irq       (irq),
    .cmp       (cmp_w),
    .run       (run_q),
    .stat      (stat_q),
    .cur       (cur_q),
    .pre       (pre_q),
    .last      (last_q)
);

// File: tb/test_dma_ring_chan.sv
module test_dma_ring_chan;
    localparam int CLK_P = 10;
    localparam logic [31:0] RING = 32'h0000_1000;

    logic        clk, rst_n, reg_wr, mem_req, mem_valid, sample_take, xfer_fault, irq;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_rdata, buf_addr;

    dma_ring_chan i_dma_ring_chan (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .sample_take(sample_take), .xfer_fault(xfer_fault),
        .buf_addr(buf_addr), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    logic [31:0] desc_ptr [32];
    logic [31:0] desc_ctl [32];
    logic        pend;
    logic [31:0] paddr;

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, e);
    endtask

    task automatic take(input int n);
        repeat (n) begin
            @(negedge clk); sample_take = 1'b1;
            @(negedge clk); sample_take = 1'b0;
        end
    endtask

    task automatic push_fetch(input int idx);
        exp_q.push_back(RING + 32'(idx) * 8);
        exp_q.push_back(RING + 32'(idx) * 8 + 4);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk); #1;
        check(tag, {31'b0, irq}, {31'b0, e});
    endtask

    // scoreboard monitor: every descriptor read must match the next expected address
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R9 unexpected fetch: actual 0x%08h expected none", mem_addr);
            end else begin
                check("R7 descriptor fetch address", mem_addr, exp_q.pop_front());
            end
        end
    end

    // memory model: answers one cycle after the request
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0; pend <= 1'b0; paddr <= '0; mem_rdata <= '0;
        end else begin
            mem_valid <= pend;
            if (pend)
                mem_rdata <= paddr[2] ? desc_ctl[5'((paddr - RING) >> 3)]
                                      : desc_ptr[5'((paddr - RING) >> 3)];
            pend  <= mem_req;
            paddr <= mem_addr;
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        sample_take = 1'b0; xfer_fault = 1'b0;
        for (int i = 0; i < 32; i++) begin
            desc_ptr[i] = 32'h0001_0000 + 32'(i) * 32'h100 + 32'h3;
            desc_ctl[i] = 32'h1;
        end
        desc_ptr[0] = 32'h0000_2003; desc_ctl[0] = 32'h0000_0003;
        desc_ptr[1] = 32'h0000_3000; desc_ctl[1] = 32'h0000_0000;
        desc_ptr[2] = 32'h0000_4002; desc_ctl[2] = 32'h8000_0002;
        desc_ptr[3] = 32'h0000_5001; desc_ctl[3] = 32'h0000_0001;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R4 reset state
        rd(4'h6, 32'h1, "R4 status reset");
        rd(4'h4, 32'h0, "R4 control reset");
        rd(4'h0, 32'h0, "R4 base reset");
        rd(4'h8, 32'h0, "R4 current reset");
        rd(4'hA, 32'h0, "R4 remaining reset");
        chk_irq(1'b0, "R12 irq after reset");

        wr(4'h0, 32'h5555_555F);
        rd(4'h0, 32'h5555_5558, "R1 base low bits cleared");
        wr(4'h5, 32'h25);
        rd(4'h5, 32'h05, "R2 last-valid modulo 32");
        wr(4'h8, 32'h1F); wr(4'h9, 32'h1F); wr(4'hA, 32'hFFFF);
        rd(4'h8, 32'h0, "R3 current read-only");
        rd(4'h9, 32'h0, "R3 prefetch read-only");
        rd(4'hA, 32'h0, "R3 remaining read-only");
        wr(4'h4, 32'hFC);
        rd(4'h4, 32'h1C, "R4 control five bits");
        rd(4'h6, 32'h1, "R6 halted while stopped");
        wr(4'h4, 32'h00);

        // start the ring
        wr(4'h0, RING);
        wr(4'h5, 32'd3);
        push_fetch(0);
        wr(4'h4, 32'h11);
        idle(12);
        rd(4'h8, 32'd0, "R5 current after start");
        rd(4'h9, 32'd1, "R5 prefetch after start");
        rd(4'h6, 32'h0, "R5 halted cleared");
        rd(4'hA, 32'd3, "R7 remaining loaded");
        check("R7 buffer address aligned", buf_addr, 32'h0000_2000);

        // d0 completes, d1 is empty, d2 loads
        push_fetch(1); push_fetch(2);
        take(3);
        idle(20);
        rd(4'h8, 32'd2, "R11 empty descriptor skipped");
        rd(4'h9, 32'd3, "R7 prefetch advanced");
        rd(4'hA, 32'd2, "R7 remaining of d2");
        rd(4'h6, 32'h0, "R11 no completion flag from empty");
        check("R7 buffer address d2", buf_addr, 32'h0000_4000);

        // d2 completes with completion flag
        push_fetch(3);
        take(2);
        idle(15);
        rd(4'h6, 32'h8, "R8 completion bit set");
        chk_irq(1'b1, "R12 completion interrupt");
        rd(4'h8, 32'd3, "R7 current at 3");
        wr(4'h6, 32'h8);
        rd(4'h6, 32'h0, "R8 write-one clears");
        chk_irq(1'b0, "R12 interrupt cleared");
        wr(4'h6, 32'h3);
        rd(4'h6, 32'h0, "R8 bits 1:0 not writable");

        // last valid buffer
        take(1);
        idle(12);
        rd(4'h6, 32'h7, "R9 end of ring status");
        rd(4'h8, 32'd3, "R9 current stays");
        rd(4'h9, 32'd4, "R9 prefetch stays");
        chk_irq(1'b0, "R12 no irq without enable");
        wr(4'h5, 32'd3);
        idle(12);
        rd(4'h6, 32'h7, "R10 equal last-valid keeps halt");

        push_fetch(4);
        wr(4'h5, 32'd5);
        idle(12);
        rd(4'h6, 32'h4, "R10 resume clears halt");
        rd(4'h8, 32'd4, "R10 current after resume");
        rd(4'h9, 32'd5, "R10 prefetch after resume");
        check("R7 buffer address d4", buf_addr, 32'h0001_0400);
        wr(4'h6, 32'h4);
        wr(4'h4, 32'h15);
        idle(10);
        rd(4'h8, 32'd4, "R5 run rewrite keeps index");
        rd(4'h4, 32'h15, "R4 control readback");

        push_fetch(5);
        take(1);
        idle(12);
        take(1);
        idle(5);
        rd(4'h6, 32'h7, "R9 halt at index 5");
        chk_irq(1'b1, "R12 last-valid interrupt");

        @(negedge clk); xfer_fault = 1'b1;
        @(negedge clk); xfer_fault = 1'b0;
        rd(4'h6, 32'h17, "R12 fault sets bit 4");
        wr(4'h4, 32'h1D);
        wr(4'h6, 32'h4);
        rd(4'h6, 32'h13, "R8 clear last-valid bit");
        chk_irq(1'b1, "R12 fault interrupt");
        wr(4'h6, 32'h10);
        rd(4'h6, 32'h3, "R8 clear fault bit");
        chk_irq(1'b0, "R12 all sources clear");

        // pause and restart
        wr(4'h4, 32'h00);
        push_fetch(0);
        wr(4'h4, 32'h01);
        idle(12);
        rd(4'h6, 32'h2, "R5 restart clears halt");
        rd(4'h8, 32'd0, "R5 restart current");
        rd(4'hA, 32'd3, "R5 restart remaining");
        wr(4'h4, 32'h00);
        rd(4'h6, 32'h3, "R6 pause sets halt");
        take(3);
        idle(5);
        rd(4'hA, 32'd3, "R6 no counting while paused");

        // register reset
        wr(4'h4, 32'h02);
        rd(4'h0, 32'h0, "R6 base after reset bit");
        rd(4'h6, 32'h1, "R6 status after reset bit");
        rd(4'h5, 32'h0, "R6 last-valid after reset bit");
        rd(4'h4, 32'h0, "R6 control after reset bit");
        rd(4'hA, 32'h0, "R6 remaining after reset bit");

        // full lap to check index wrap
        for (int i = 0; i < 32; i++) desc_ctl[i] = 32'h1;
        wr(4'h0, RING);
        wr(4'h5, 32'd31);
        for (int i = 0; i < 32; i++) push_fetch(i);
        wr(4'h4, 32'h01);
        for (int i = 0; i < 32; i++) begin
            idle(12);
            take(1);
        end
        idle(10);
        rd(4'h6, 32'h7, "R9 halt at index 31");
        rd(4'h8, 32'd31, "R7 current at 31");
        rd(4'h9, 32'd0, "R7 prefetch wraps to 0");
        push_fetch(0);
        wr(4'h5, 32'd0);
        idle(12);
        rd(4'h8, 32'd0, "R10 resume across wrap");
        rd(4'h9, 32'd1, "R10 prefetch after wrap");

        idle(20);
        check("R9 pending fetches", 32'(exp_q.size()), 32'd0);
        summary();
        $finish;
    end

endmodule